// File: doc/BRIEF.md
# Control-Word Steered Register Datapath

This block is the execution half of a small multi-cycle processor. Every clock it takes one packed 14-bit control word that names two source registers, a destination register, a function, and two operand/writeback selections. From these it reads a four-entry, 4-bit register file through two independent read ports. It passes the operands through an ALU or a zero-fill shifter and drives the memory address and store-data buses. It reports overflow, sign, carry and zero flags for the function result.

A sequencer outside the block supplies the control word, an immediate constant and the word returned by memory. Only the register file holds state and it writes on the rising clock edge. All outputs are combinational from the current register contents and the current inputs. An active-low asynchronous reset clears the registers.

Top module: `cw_datapath`

## Requirements
- R1: While `rst_n` is low, all four registers are cleared to 0, so every read port returns 0 after reset.
- R2: Control word bit 0 is the write enable. When it is 1, the register selected by bits [13:12] is loaded with the writeback value at the rising clock edge. When it is 0, no register changes.
- R3: `addr_out` is the register selected by bits [11:10]. The second read port is selected by bits [9:8]. Both ports read in the same cycle and return the value held before any write at the coming edge.
- R4: Bit 7 selects the B operand. At 1 the constant input is used, and at 0 the register from the second read port is used. `data_out` carries that same selected B operand.
- R5: Bit 1 selects the writeback value. At 1 it is `mem_rdata`, and at 0 it is the function result. The flags always describe the function result.
- R6: The function code is bits [6:2]. The arithmetic codes are 00000 = A, 00001 = A+1, 00010 = A+B, 00101 = A-B and 00110 = A-1, all modulo 16. C is the adder carry-out, so for A-B, C=1 exactly when A >= B unsigned. V is two's-complement overflow of the operation.
- R7: The logic codes are 01000 = A AND B, 01010 = A OR B, 01100 = A XOR B and 01110 = NOT A. For these codes C and V are 0.
- R8: The shifter codes are 10000 = B, 10100 = B shifted right by one, and 11000 = B shifted left by one. The vacated bit is always 0, and C and V are 0.
- R9: Z is 1 exactly when the 4-bit result is 0. N equals result bit 3.
- R10: Any other function code yields the result A with C and V equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; register writes on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the register file |
| ctrl_word | input | 14 | Packed control word for this cycle |
| const_in | input | 4 | Immediate constant operand |
| mem_rdata | input | 4 | Word read from memory, writeback candidate |
| addr_out | output | 4 | Memory address, first read port |
| data_out | output | 4 | Memory store data, selected B operand |
| flag_v | output | 1 | Signed overflow of the result |
| flag_n | output | 1 | Sign bit of the result |
| flag_c | output | 1 | Adder carry-out |
| flag_z | output | 1 | Result is zero |

## Verification
The assertions check several properties on every cycle. A register changes only when the write enable is set, and a written register holds the writeback value on the next cycle. Addition agrees with the two bus outputs including carry. Non-arithmetic and unlisted codes never raise C or V, and unlisted codes pass A through. Only the bench scenarios can show the full function table over all 256 operand pairs, the exact overflow cases of increment, decrement and subtraction, zero-fill shifting, and memory-data writeback. They also cover reset clearing, reading the same register on both ports, and the old value being read during a write.

// File: rtl/dp_pkg.sv
package dp_pkg;
  localparam int FSW = 5;
  localparam logic [FSW-1:0] FS_PASSA = 5'b00000;
  localparam logic [FSW-1:0] FS_INC   = 5'b00001;
  localparam logic [FSW-1:0] FS_ADD   = 5'b00010;
  localparam logic [FSW-1:0] FS_SUB   = 5'b00101;
  localparam logic [FSW-1:0] FS_DEC   = 5'b00110;
  localparam logic [FSW-1:0] FS_AND   = 5'b01000;
  localparam logic [FSW-1:0] FS_OR    = 5'b01010;
  localparam logic [FSW-1:0] FS_XOR   = 5'b01100;
  localparam logic [FSW-1:0] FS_NOTA  = 5'b01110;
  localparam logic [FSW-1:0] FS_PASSB = 5'b10000;
  localparam logic [FSW-1:0] FS_SHR   = 5'b10100;
  localparam logic [FSW-1:0] FS_SHL   = 5'b11000;

  // two's-complement overflow from operand and sum sign bits
  function automatic logic sgn_ovf(input logic a_msb, input logic y_msb, input logic s_msb);
    return (a_msb == y_msb) && (s_msb != a_msb);
  endfunction
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DW = 4,
  parameter int NREG = 4,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_a_addr,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_a_data,
  output logic [DW-1:0] rd_b_data
);
  logic [NREG-1:0][DW-1:0] mem;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == AW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem[gi] <= '0;
      else if (hit) mem[gi] <= wr_data;
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));
  assert_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int DW = 4
) (
  input  logic [DW-1:0]          a,
  input  logic [DW-1:0]          b,
  input  logic [dp_pkg::FSW-1:0] op,
  output logic [DW-1:0]          y,
  output logic                   c,
  output logic                   v,
  output logic                   arith,
  output logic                   known
);
  import dp_pkg::*;
  logic [DW-1:0] add_y;
  logic          add_cin;
  logic [DW:0]   sum;

  always_comb begin
    add_y = '0;
    add_cin = 1'b0;
    arith = 1'b1;
    known = 1'b1;
    unique case (op)
      FS_PASSA: ;
      FS_INC:   add_cin = 1'b1;
      FS_ADD:   add_y = b;
      FS_SUB:   begin add_y = ~b; add_cin = 1'b1; end
      FS_DEC:   add_y = '1;
      FS_AND, FS_OR, FS_XOR, FS_NOTA: arith = 1'b0;
      default:  begin arith = 1'b0; known = 1'b0; end
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, add_y} + {{DW{1'b0}}, add_cin};

  always_comb begin
    case (op)
      FS_AND:  y = a & b;
      FS_OR:   y = a | b;
      FS_XOR:  y = a ^ b;
      FS_NOTA: y = ~a;
      default: y = arith ? sum[DW-1:0] : a;
    endcase
  end

  assign c = arith && sum[DW];
  assign v = arith && sgn_ovf(a[DW-1], add_y[DW-1], sum[DW-1]);
endmodule

// File: rtl/dp_shifter.sv
module dp_shifter #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] b,
  input  logic [1:0]    sel,
  output logic [DW-1:0] h
);
  always_comb begin
    case (sel)
      2'd0:    h = b;
      2'd1:    h = {1'b0, b[DW-1:1]};
      2'd2:    h = {b[DW-2:0], 1'b0};
      default: h = '0;
    endcase
  end
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath #(
  parameter int DW = 4,
  parameter int NREG = 4,
  localparam int AW = $clog2(NREG),
  localparam int CWW = 8 + 3 * AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CWW-1:0] ctrl_word,
  input  logic [DW-1:0]  const_in,
  input  logic [DW-1:0]  mem_rdata,
  output logic [DW-1:0]  addr_out,
  output logic [DW-1:0]  data_out,
  output logic           flag_v,
  output logic           flag_n,
  output logic           flag_c,
  output logic           flag_z
);
  import dp_pkg::*;
  localparam int BA_LO = 8;
  localparam int AA_LO = BA_LO + AW;
  localparam int DA_LO = AA_LO + AW;

  logic [AW-1:0]  dst_sel, rda_sel, rdb_sel;
  logic           use_const, use_mem, wr_en;
  logic [FSW-1:0] func_sel;
  assign dst_sel   = ctrl_word[DA_LO +: AW];
  assign rda_sel   = ctrl_word[AA_LO +: AW];
  assign rdb_sel   = ctrl_word[BA_LO +: AW];
  assign use_const = ctrl_word[7];
  assign func_sel  = ctrl_word[6:2];
  assign use_mem   = ctrl_word[1];
  assign wr_en     = ctrl_word[0];

  logic [DW-1:0] rd_a, rd_b, op_b, wb_data, fu_result, alu_y, sh_y;
  logic alu_c, alu_v, alu_arith, alu_known, shift_op, code_known;

  dp_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(dst_sel), .wr_data(wb_data),
    .rd_a_addr(rda_sel), .rd_b_addr(rdb_sel), .rd_a_data(rd_a), .rd_b_data(rd_b));

  assign op_b = use_const ? const_in : rd_b;

  dp_alu #(.DW(DW)) u_alu (
    .a(rd_a), .b(op_b), .op(func_sel), .y(alu_y), .c(alu_c), .v(alu_v),
    .arith(alu_arith), .known(alu_known));

  dp_shifter #(.DW(DW)) u_sh (.b(op_b), .sel(func_sel[3:2]), .h(sh_y));

  assign shift_op   = func_sel[4] && (func_sel[1:0] == 2'b00) && (func_sel[3:2] != 2'b11);
  assign code_known = shift_op || alu_known;
  assign fu_result  = shift_op ? sh_y : alu_y;
  assign wb_data    = use_mem ? mem_rdata : fu_result;

  assign addr_out = rd_a;
  assign data_out = op_b;
  assign flag_c   = !shift_op && alu_c;
  assign flag_v   = !shift_op && alu_v;
  assign flag_n   = fu_result[DW-1];
  assign flag_z   = (fu_result == '0);

  assert_add_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (func_sel == FS_ADD) |-> ({flag_c, fu_result} == ({1'b0, addr_out} + {1'b0, data_out})));
  assert_flagclr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_arith |-> (!flag_c && !flag_v));
  assert_unlisted_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !code_known |-> (fu_result == addr_out && !flag_c && !flag_v));
endmodule

// File: tb/sim_cw_datapath.sv
module sim_cw_datapath;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] ctrl = '0;
  logic [3:0] kin = '0, mdin = '0;
  logic [3:0] addr_out, data_out;
  logic fv, fn, fc, fz;
  int compared = 0, mismatched = 0;
  int rf[4];
  bit done = 0;

  always #2 clk = ~clk;

  cw_datapath u0 (.clk(clk), .rst_n(rst_n), .ctrl_word(ctrl), .const_in(kin),
    .mem_rdata(mdin), .addr_out(addr_out), .data_out(data_out),
    .flag_v(fv), .flag_n(fn), .flag_c(fc), .flag_z(fz));

  function automatic logic [13:0] mk(int da, int aa, int ba, int mb, int fs, int md, int rw);
    return 14'((da << 12) | (aa << 10) | (ba << 8) | (mb << 7) | (fs << 2) | (md << 1) | rw);
  endfunction

  function automatic int sx(int x);
    return (x > 7) ? x - 16 : x;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare, model the edge
  task automatic step(logic [13:0] cw, int k, int m, string tag);
    int a, b, res, c, v, s, fs;
    ctrl = cw; kin = 4'(k); mdin = 4'(m);
    #1;
    a = rf[cw[11:10]];
    b = cw[7] ? k : rf[cw[9:8]];
    fs = cw[6:2];
    c = 0; v = 0;
    case (fs)
      1:  begin res = a + 1; s = sx(a) + 1; end
      2:  begin res = a + b; s = sx(a) + sx(b); end
      5:  begin res = a - b + 16; s = sx(a) - sx(b); end
      6:  begin res = a + 15; s = sx(a) - 1; end
      8:  res = a & b;
      10: res = a | b;
      12: res = a ^ b;
      14: res = 15 - a;
      16: res = b;
      20: res = b / 2;
      24: res = (b * 2) % 16;
      default: res = a;
    endcase
    if (fs inside {1, 2, 5, 6}) begin
      c = (res > 15) ? 1 : 0;
      v = (s > 7 || s < -8) ? 1 : 0;
    end
    res = res % 16;
    chk(tag, "addr_out", addr_out, a);
    chk(tag, "data_out", data_out, b);
    chk(tag, "flag_c", fc, c);
    chk(tag, "flag_v", fv, v);
    chk(tag, "flag_n", fn, res / 8);
    chk(tag, "flag_z", fz, (res == 0) ? 1 : 0);
    @(posedge clk);
    if (cw[0]) rf[cw[13:12]] = cw[1] ? m : res;
    @(negedge clk);
  endtask

  task automatic load(int r, int val);
    step(mk(r, 0, 0, 1, 16, 0, 1), val, 0, "R4");
  endtask

  initial begin
    int codes[14] = '{0, 1, 2, 5, 6, 8, 10, 12, 14, 16, 20, 24, 3, 31};
    string tag;
    foreach (rf[i]) rf[i] = 0;
    rf[0] = 9; rf[3] = 5;
    // R1: seeded values are lost in reset, model goes back to zero
    @(negedge clk);
    foreach (rf[i]) rf[i] = 0;
    for (int i = 0; i < 4; i++) step(mk(0, i, i, 0, 0, 0, 0), 0, 0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    // R2/R3: write then read on both ports, incl. old value during write
    load(1, 6);
    load(2, 11);
    step(mk(2, 2, 2, 0, 2, 0, 1), 0, 0, "R3");
    step(mk(0, 2, 1, 0, 0, 0, 0), 0, 0, "R3");
    // R2: write enable low leaves registers alone
    step(mk(1, 1, 1, 1, 16, 1, 0), 3, 7, "R2");
    step(mk(0, 1, 2, 0, 0, 0, 0), 0, 0, "R2");
    // R5: memory writeback
    step(mk(3, 0, 0, 1, 12, 1, 1), 5, 13, "R5");
    step(mk(0, 3, 3, 0, 0, 0, 0), 0, 0, "R5");
    // R6-R10: every code over every operand pair
    foreach (codes[j]) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          load(1, a);
          tag = (codes[j] inside {0, 1, 2, 5, 6}) ? "R6" :
                (codes[j] inside {8, 10, 12, 14}) ? "R7" :
                (codes[j] inside {16, 20, 24}) ? "R8" : "R10";
          step(mk(3, 1, 2, 1, codes[j], 0, 1), b, 0, tag);
          step(mk(0, 3, 3, 0, 0, 0, 0), 0, 0, "R9");
        end
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule